// File: doc/BRIEF.md
# Dual Maskable Time/Date Alarm Unit

This block watches the running time of a clock/calendar and raises two independent alarms. On every once-per-second update strobe it compares the current seconds, minutes, hours, day-of-week and date against the contents of two alarm register sets. Alarm 1 has four bytes: seconds, minutes, hours and day/date. Alarm 2 has three bytes: minutes, hours and day/date. Alarm 2 only fires at second 00. Bit 7 of every alarm byte is a mask: when it is set, that byte takes no part in the match. This gives repeat rates that range from every second (or every minute for alarm 2) up to a full day-or-date match.

Each alarm owns a sticky flag. A match sets the flag. Software clears a flag by writing 0 to its bit. Writing 1 to a flag bit leaves it as it is. The single active-low output has two modes. It either signals an interrupt from the flags that are enabled, or it passes through an externally generated square-wave level. A control input selects the mode.

Top module: `dual_alarm_unit`

## Requirements
- R1: After the synchronous reset, both alarm flags are 0, and `out_n` is high in interrupt mode.
- R2: Matches are evaluated only in cycles where `tick_1hz` is 1. Matching values held while the strobe is 0 never set a flag.
- R3: When bit 7 is set in all four alarm-1 bytes, alarm-1's flag sets on every strobe.
- R4: For each seconds and minutes byte with bit 7 clear, bits 6:0 must equal the current BCD field. Each byte that is unmasked narrows the match.
- R5: An unmasked hours byte compares its bits 6:0 as stored against the current hours value. This includes bit 6 (12/24 select) and bit 5 (AM/PM or tens of hours).
- R6: In an unmasked day/date byte, bit 6 selects the target. A value of 1 compares bits 5:0 with the day of week. A value of 0 compares them with the date.
- R7: Alarm 2 can match only when the current seconds field is 00h. With all three of its bytes masked, it fires once per minute.
- R8: A match sets its flag whether or not interrupt mode is selected.
- R9: A cycle with `flag_wr`=1 clears each flag whose bit in `flag_wr_data` is 0 (bit 0 = alarm 1, bit 1 = alarm 2). A bit of 1 leaves its flag unchanged. A match in the same cycle wins over the clear.
- R10: With `irq_mode`=1, `out_n` is low exactly while some flag is 1 and its bit in `alarm_en` is 1 (bit 0 = alarm 1, bit 1 = alarm 2). It returns high only when every such flag has been cleared.
- R11: With `irq_mode`=0, `out_n` equals `sqw_in`, whatever the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle strobe marking the per-second time update |
| cur_sec | input | 7 | Current BCD seconds |
| cur_min | input | 7 | Current BCD minutes |
| cur_hour | input | 7 | Current hours byte (12/24 bit, AM/PM or tens, units) |
| cur_dow | input | 6 | Current day of week |
| cur_date | input | 6 | Current BCD date of month |
| a1_sec | input | 8 | Alarm 1 seconds byte, bit 7 mask |
| a1_min | input | 8 | Alarm 1 minutes byte, bit 7 mask |
| a1_hour | input | 8 | Alarm 1 hours byte, bit 7 mask |
| a1_dd | input | 8 | Alarm 1 day/date byte: bit 7 mask, bit 6 day select, bits 5:0 value |
| a2_min | input | 8 | Alarm 2 minutes byte, bit 7 mask |
| a2_hour | input | 8 | Alarm 2 hours byte, bit 7 mask |
| a2_dd | input | 8 | Alarm 2 day/date byte, same layout as alarm 1 |
| irq_mode | input | 1 | 1 = interrupt output, 0 = square-wave pass-through |
| alarm_en | input | 2 | Per-alarm interrupt enables |
| flag_wr | input | 1 | Flag write strobe |
| flag_wr_data | input | 2 | Flag write data; 0 clears, 1 keeps |
| sqw_in | input | 1 | Square-wave level used when not in interrupt mode |
| alarm_flag | output | 2 | Sticky alarm flags |
| out_n | output | 1 | Active-low interrupt or square-wave output |

## Verification
The match logic is tested with four stimulus patterns:
- All bytes masked. This shows that alarm 1 fires on every strobe and alarm 2 only at second 00.
- A single unmasked seconds byte, tested against a value that is one off and then against an equal value.
- An hours byte that differs from the current hours only in the AM/PM bit. This shows the stored bits are compared literally.
- Day/date pairs in which the day of week and the date hold each other's values. These show which target the select bit picks.

Flag-write patterns of 11, 10 and 01 are applied to both flags, including one write that coincides with a match. These separate clearing from keeping, and show the write-versus-match priority. The output is tested with one flag enabled and the other flag set but disabled, and with a toggling square wave, to separate the two output modes.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    localparam int BYTE_W  = 8;
    localparam int VAL_W   = 7;
    localparam int DD_W    = 6;
    localparam int NUM_ALM = 2;
    localparam int MASK_B  = BYTE_W - 1;
    localparam int SEL_B   = BYTE_W - 2;

    // Fixed seconds byte for the alarm without its own seconds register:
    // unmasked, value 00 -> matches only at the top of the minute.
    localparam logic [BYTE_W-1:0] SEC_AT_ZERO = '0;

    typedef struct packed {
        logic [VAL_W-1:0] sec;
        logic [VAL_W-1:0] min;
        logic [VAL_W-1:0] hour;
        logic [DD_W-1:0]  dow;
        logic [DD_W-1:0]  date;
    } now_t;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] dd;
    } alarm_cfg_t;

    typedef struct packed {
        logic sec;
        logic min;
        logic hour;
        logic dd;
    } field_hits_t;

    function automatic logic byte_ok(input logic [BYTE_W-1:0] cfg,
                                     input logic [VAL_W-1:0]  cur);
        return cfg[MASK_B] || (cfg[VAL_W-1:0] == cur);
    endfunction

    function automatic logic dd_ok(input logic [BYTE_W-1:0] cfg,
                                   input now_t              now);
        logic [DD_W-1:0] target;
        target = cfg[SEL_B] ? now.dow : now.date;
        return cfg[MASK_B] || (cfg[DD_W-1:0] == target);
    endfunction

endpackage

// File: rtl/alm_match.sv
module alm_match
    import alarm_pkg::*;
(
    input  alarm_cfg_t cfg,
    input  now_t       now,
    output logic       hit
);
    field_hits_t hits;

    always_comb begin
        hits.sec  = byte_ok(cfg.sec,  now.sec);
        hits.min  = byte_ok(cfg.min,  now.min);
        hits.hour = byte_ok(cfg.hour, now.hour);
        hits.dd   = dd_ok(cfg.dd, now);
        hit       = &hits;
    end
endmodule

// File: rtl/alm_flag.sv
module alm_flag (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic hit,
    input  logic clr,
    output logic flag
);
    logic set_now;
    assign set_now = tick & hit;

    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= set_now | (flag & ~clr);
    end
endmodule

// File: rtl/alm_out.sv
module alm_out #(
    parameter int N = 2
) (
    input  logic         irq_mode,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] en,
    input  logic         sqw,
    output logic         out_n
);
    logic req;
    assign req   = |(flags & en);
    assign out_n = irq_mode ? ~req : sqw;
endmodule

// File: rtl/dual_alarm_unit.sv
module dual_alarm_unit
    import alarm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_1hz,
    input  logic [VAL_W-1:0]    cur_sec,
    input  logic [VAL_W-1:0]    cur_min,
    input  logic [VAL_W-1:0]    cur_hour,
    input  logic [DD_W-1:0]     cur_dow,
    input  logic [DD_W-1:0]     cur_date,
    input  logic [BYTE_W-1:0]   a1_sec,
    input  logic [BYTE_W-1:0]   a1_min,
    input  logic [BYTE_W-1:0]   a1_hour,
    input  logic [BYTE_W-1:0]   a1_dd,
    input  logic [BYTE_W-1:0]   a2_min,
    input  logic [BYTE_W-1:0]   a2_hour,
    input  logic [BYTE_W-1:0]   a2_dd,
    input  logic                irq_mode,
    input  logic [NUM_ALM-1:0]  alarm_en,
    input  logic                flag_wr,
    input  logic [NUM_ALM-1:0]  flag_wr_data,
    input  logic                sqw_in,
    output logic [NUM_ALM-1:0]  alarm_flag,
    output logic                out_n
);
    now_t       now;
    alarm_cfg_t cfg [NUM_ALM];
    logic [NUM_ALM-1:0] hit;

    assign now = '{sec: cur_sec, min: cur_min, hour: cur_hour,
                   dow: cur_dow, date: cur_date};

    generate
        for (genvar g = 0; g < NUM_ALM; g++) begin : g_alm
            if (g == 0) begin : g_full
                assign cfg[g] = '{sec: a1_sec, min: a1_min, hour: a1_hour, dd: a1_dd};
            end else begin : g_no_sec
                assign cfg[g] = '{sec: SEC_AT_ZERO, min: a2_min, hour: a2_hour, dd: a2_dd};
            end

            alm_match u_match (
                .cfg (cfg[g]),
                .now (now),
                .hit (hit[g])
            );

            alm_flag u_flag (
                .clk  (clk),
                .rst  (rst),
                .tick (tick_1hz),
                .hit  (hit[g]),
                .clr  (flag_wr & ~flag_wr_data[g]),
                .flag (alarm_flag[g])
            );
        end
    endgenerate

    alm_out #(.N(NUM_ALM)) u_out (
        .irq_mode (irq_mode),
        .flags    (alarm_flag),
        .en       (alarm_en),
        .sqw      (sqw_in),
        .out_n    (out_n)
    );
endmodule

// File: rtl/dual_alarm_chk.sv
module dual_alarm_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick_1hz,
    input logic [3:0] a1_masks,
    input logic [6:0] cur_sec,
    input logic       flag_wr,
    input logic [1:0] flag_wr_data,
    input logic [1:0] alarm_flag
);
    a_r2_no_set_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick_1hz && !alarm_flag[0]) |=> !alarm_flag[0]);

    a_r3_all_masked_fires: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && (&a1_masks)) |=> alarm_flag[0]);

    a_r7_alarm2_only_at_zero: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && cur_sec != 7'h00 && !alarm_flag[1]) |=> !alarm_flag[1]);

    a_r9_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && !flag_wr_data[0] && !tick_1hz) |=> !alarm_flag[0]);

    a_r9_one_keeps: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag[1] && !(flag_wr && !flag_wr_data[1])) |=> alarm_flag[1]);
endmodule

bind dual_alarm_unit dual_alarm_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick_1hz     (tick_1hz),
    .a1_masks     ({a1_sec[7], a1_min[7], a1_hour[7], a1_dd[7]}),
    .cur_sec      (cur_sec),
    .flag_wr      (flag_wr),
    .flag_wr_data (flag_wr_data),
    .alarm_flag   (alarm_flag)
);

// File: tb/dual_alarm_unit_tb.sv
module dual_alarm_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 0;
    logic rst = 1;
    logic tick_1hz = 0;
    logic [6:0] cur_sec = 0, cur_min = 0, cur_hour = 0;
    logic [5:0] cur_dow = 1, cur_date = 1;
    logic [7:0] a1_sec = 8'h80, a1_min = 8'h80, a1_hour = 8'h80, a1_dd = 8'h80;
    logic [7:0] a2_min = 8'h80, a2_hour = 8'h80, a2_dd = 8'h80;
    logic irq_mode = 0;
    logic [1:0] alarm_en = 0;
    logic flag_wr = 0;
    logic [1:0] flag_wr_data = 2'b11;
    logic sqw_in = 1;
    logic [1:0] alarm_flag;
    logic out_n;

    int tests = 0;
    int fails = 0;
    logic [1:0] exp_flag;

    dual_alarm_unit u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural expectation of one alarm's match.
    function automatic bit model_hit(int a);
        bit ok = 1;
        logic [7:0] m, h, d;
        logic [5:0] tgt;
        if (a == 0) begin
            if (!a1_sec[7] && a1_sec[6:0] != cur_sec) ok = 0;
            m = a1_min; h = a1_hour; d = a1_dd;
        end else begin
            if (cur_sec != 7'h00) ok = 0;
            m = a2_min; h = a2_hour; d = a2_dd;
        end
        if (!m[7] && m[6:0] != cur_min)  ok = 0;
        if (!h[7] && h[6:0] != cur_hour) ok = 0;
        tgt = d[6] ? cur_dow : cur_date;
        if (!d[7] && d[5:0] != tgt) ok = 0;
        return ok;
    endfunction

    function automatic logic model_out();
        if (!irq_mode) return sqw_in;
        return !((exp_flag[0] && alarm_en[0]) || (exp_flag[1] && alarm_en[1]));
    endfunction

    always @(posedge clk) begin
        logic [1:0] nf;
        if (rst) exp_flag <= 2'b00;
        else begin
            nf = exp_flag;
            for (int a = 0; a < 2; a++) begin
                if (flag_wr && !flag_wr_data[a]) nf[a] = 0;
                if (tick_1hz && model_hit(a))    nf[a] = 1;
            end
            exp_flag <= nf;
        end
    end

    // Per-cycle comparison against the model, away from the edge.
    always begin
        @(posedge clk);
        #1;
        if (!rst) begin
            tests++;
            if (alarm_flag !== exp_flag || out_n !== model_out()) begin
                fails++;
                $display("FAIL model R9/R10: flags=%b out_n=%b expected flags=%b out_n=%b",
                         alarm_flag, out_n, exp_flag, model_out());
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse();
        @(negedge clk) tick_1hz = 1;
        @(negedge clk) tick_1hz = 0;
    endtask

    task automatic write_flags(logic [1:0] d);
        @(negedge clk) begin flag_wr = 1; flag_wr_data = d; end
        @(negedge clk) begin flag_wr = 0; flag_wr_data = 2'b11; end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 flags after reset", alarm_flag, 0);
        irq_mode = 1; #1;
        chk("R1 out_n idle in irq mode", out_n, 1);

        // R2 match present but no strobe
        cur_sec = 7'h10; cur_min = 7'h20; cur_hour = 7'h08; cur_dow = 2; cur_date = 6'h15;
        a1_sec = 8'h10; a1_min = 8'h20; a1_hour = 8'h08; a1_dd = 8'h15;
        repeat (4) @(negedge clk);
        chk("R2 no strobe no flag", alarm_flag[0], 0);
        pulse();
        chk("R4 full match sets flag1", alarm_flag[0], 1);
        write_flags(2'b10);

        // R3 all masked
        a1_sec = 8'h80; a1_min = 8'h80; a1_hour = 8'h80; a1_dd = 8'h80;
        cur_sec = 7'h37;
        pulse();
        chk("R3 every-second alarm", alarm_flag[0], 1);
        write_flags(2'b10);
        chk("R9 clear flag1", alarm_flag[0], 0);

        // R4 seconds only, then seconds+minutes
        a1_sec = 8'h25; cur_sec = 7'h24;
        pulse();
        chk("R4 seconds mismatch", alarm_flag[0], 0);
        cur_sec = 7'h25;
        pulse();
        chk("R4 seconds match", alarm_flag[0], 1);
        write_flags(2'b10);
        a1_min = 8'h44; cur_min = 7'h43;
        pulse();
        chk("R4 minutes narrow match", alarm_flag[0], 0);

        // R5 hours literal compare incl AM/PM
        a1_sec = 8'h80; a1_min = 8'h80; a1_hour = 8'h52; cur_hour = 7'h72;
        pulse();
        chk("R5 PM vs AM mismatch", alarm_flag[0], 0);
        cur_hour = 7'h52;
        pulse();
        chk("R5 hours match as stored", alarm_flag[0], 1);
        write_flags(2'b10);

        // R6 day/date select
        a1_hour = 8'h80; a1_dd = 8'h43; cur_dow = 3; cur_date = 5;
        pulse();
        chk("R6 day-of-week match", alarm_flag[0], 1);
        write_flags(2'b10);
        cur_dow = 5; cur_date = 3;
        pulse();
        chk("R6 day select ignores date", alarm_flag[0], 0);
        a1_dd = 8'h03;
        pulse();
        chk("R6 date match", alarm_flag[0], 1);
        write_flags(2'b10);
        a1_dd = 8'h80;

        // R7 alarm2 once per minute
        cur_sec = 7'h30;
        pulse();
        chk("R7 alarm2 not at 30s", alarm_flag[1], 0);
        cur_sec = 7'h00;
        pulse();
        chk("R7 alarm2 at 00s", alarm_flag[1], 1);

        // R9 write of 1 keeps, 01 clears flag2 only
        write_flags(2'b11);
        chk("R9 write one keeps flag2", alarm_flag[1], 1);
        write_flags(2'b01);
        chk("R9 clear flag2", alarm_flag[1], 0);

        // R8 flag sets in square-wave mode
        irq_mode = 0;
        pulse();
        chk("R8 flags set with irq_mode=0", alarm_flag, 3);

        // R9 same-cycle match beats clear
        @(negedge clk) begin tick_1hz = 1; flag_wr = 1; flag_wr_data = 2'b10; end
        @(negedge clk) begin tick_1hz = 0; flag_wr = 0; flag_wr_data = 2'b11; end
        chk("R9 match wins over clear", alarm_flag[0], 1);

        // R11 square-wave pass-through
        sqw_in = 0; #1;
        chk("R11 out follows sqw low", out_n, 0);
        sqw_in = 1; #1;
        chk("R11 out follows sqw high", out_n, 1);

        // R10 interrupt output
        irq_mode = 1; alarm_en = 2'b01; #1;
        chk("R10 enabled flag1 asserts", out_n, 0);
        write_flags(2'b10);
        chk("R10 disabled flag2 does not assert", out_n, 1);
        alarm_en = 2'b11; #1;
        chk("R10 enabling flag2 asserts", out_n, 0);
        write_flags(2'b01);
        chk("R10 all cleared releases", out_n, 1);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule